// File: doc/BRIEF.md
# Coin-Accepting Vending Controller

This block tracks the credit inserted into a vending slot that takes only two kinds of coin: a five-cent piece and a ten-cent piece. It keeps the credit in a two-bit state register with four states. When the credit reaches fifteen cents, the release output asserts and the credit returns to zero. The release decision is a Mealy function: it uses the present credit and the coin arriving in the same cycle. A coin that completes the price therefore opens the slot in that cycle.

A build parameter selects how the release output leaves the block. In the direct mode, the output is the combinational Mealy term. In the registered mode, that term passes through one extra flip-flop, so the output appears one cycle later. In that mode the output reflects the previous state and the coin that caused the last transition.

A synchronous, active-high reset returns the credit to zero and holds the release output low. A coin strobe lasts one cycle. The five-cent and ten-cent strobes are never high in the same cycle.

The states are CR_ZERO (credit 0), CR_FIVE (credit 5), CR_TEN (credit 10) and CR_FULL (credit 15). The transitions are:
- CR_ZERO→CR_FIVE on a five-cent coin.
- CR_ZERO→CR_TEN on a ten-cent coin.
- CR_FIVE→CR_TEN on a five-cent coin.
- CR_FIVE→CR_FULL on a ten-cent coin.
- CR_TEN→CR_ZERO on either coin, with release.
- CR_FULL→CR_ZERO always, with release.
- Every other state holds when no coin arrives.

Top module: `vend_ctrl`

## Requirements
- R1: The credit is encoded on `credit_o` as 00 = 0, 01 = 5, 10 = 10 and 11 = 15 cents. When `rst_i` is high at a rising edge, the credit is 00 after that edge.
- R2: A five-cent coin (`nickel_i`) moves the credit from 00 to 01, and from 01 to 10, at the next edge.
- R3: A ten-cent coin (`dime_i`) moves the credit from 00 to 10, and from 01 to 11, at the next edge. `open_o` stays low in both cases.
- R4: With no coin, the credit in states 00, 01 and 10 is unchanged after the edge.
- R5: In direct mode (REG_OUT = 0), `open_o` is high in the same cycle that either coin arrives while the credit is 10.
- R6: While the credit is 11, the release term is high whether or not a coin arrives.
- R7: After any cycle in which the release term is high, the credit is 00 at the next edge.
- R8: In registered mode (REG_OUT = 1), `open_o` in each cycle equals the reset-gated release term of the previous cycle.
- R9: While `rst_i` is high, the release term is forced low. In direct mode `open_o` is low in that cycle. In registered mode it is low in the following cycle.
- R10: While the credit is 00 or 01, the release term is low for every coin input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle strobe for a five-cent coin |
| dime_i | input | 1 | One-cycle strobe for a ten-cent coin |
| open_o | output | 1 | Release output, direct or registered per REG_OUT |
| credit_o | output | 2 | Present credit state |

## Verification
The bench builds two copies of the block, one with REG_OUT = 0 and one with REG_OUT = 1, and drives both with the same coin stream. The direct copy exposes the same-cycle Mealy release: a coin arriving at credit 10 opens the slot at once. The registered copy must show that same pulse exactly one cycle later, together with the reset gating of the extra flop. Comparing the two copies against a single behavioural model shows that the next-state logic is identical in both modes and that only the output timing differs.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_FULL = 2'b11
    } credit_e;

endpackage

// File: rtl/vend_next.sv
module vend_next
    import vend_pkg::*;
(
    input  credit_e cur_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    input  logic    fire_i,
    output credit_e nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (fire_i) begin
            nxt_o = CR_ZERO;
        end else begin
            unique case (cur_i)
                CR_ZERO: begin
                    if (dime_i)        nxt_o = CR_TEN;
                    else if (nickel_i) nxt_o = CR_FIVE;
                    else               nxt_o = CR_ZERO;
                end
                CR_FIVE: begin
                    if (dime_i)        nxt_o = CR_FULL;
                    else if (nickel_i) nxt_o = CR_TEN;
                    else               nxt_o = CR_FIVE;
                end
                CR_TEN:  nxt_o = CR_TEN;
                CR_FULL: nxt_o = CR_ZERO;
                default: nxt_o = CR_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
    import vend_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    input  credit_e nxt_i,
    output credit_e cur_o
);

    credit_e state_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= CR_ZERO;
        else       state_q <= nxt_i;
    end

    assign cur_o = state_q;

    AST_RESET_ZERO: assert property (@(posedge clk_i)
        rst_i |=> (state_q == CR_ZERO)); // R1

    AST_NICKEL_FROM_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == CR_ZERO && nickel_i && !dime_i) |=> (state_q == CR_FIVE)); // R2

    AST_DIME_FROM_FIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == CR_FIVE && dime_i && !nickel_i) |=> (state_q == CR_FULL)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!nickel_i && !dime_i && state_q != CR_FULL) |=> $stable(state_q)); // R4

endmodule

// File: rtl/vend_out.sv
module vend_out
    import vend_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
)(
    input  logic    clk_i,
    input  logic    rst_i,
    input  credit_e cur_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    output logic    fire_o,
    output logic    open_o
);

    logic gated;

    always_comb begin
        unique case (cur_i)
            CR_ZERO: fire_o = 1'b0;
            CR_FIVE: fire_o = 1'b0;
            CR_TEN:  fire_o = nickel_i | dime_i;
            CR_FULL: fire_o = 1'b1;
            default: fire_o = 1'b0;
        endcase
    end

    assign gated = fire_o & ~rst_i;

    AST_LOW_BELOW_TEN: assert property (@(posedge clk_i)
        (cur_i == CR_ZERO || cur_i == CR_FIVE) |-> !fire_o); // R10

    generate
        if (REG_OUT) begin : g_reg
            logic open_q;
            always_ff @(posedge clk_i) begin
                open_q <= gated;
            end
            assign open_o = open_q;

            AST_REG_RST_MUTES: assert property (@(posedge clk_i)
                rst_i |=> !open_o); // R9
            AST_REG_FULL_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
                (cur_i == CR_FULL) |=> open_o); // R6
            AST_REG_DELAY: assert property (@(posedge clk_i) disable iff (rst_i)
                (cur_i == CR_TEN && (nickel_i || dime_i)) |=> open_o); // R8
        end else begin : g_comb
            assign open_o = gated;

            AST_RST_MUTES: assert property (@(posedge clk_i)
                rst_i |-> !open_o); // R9
            AST_FULL_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
                (cur_i == CR_FULL) |-> open_o); // R6
            AST_TEN_COIN_OPENS: assert property (@(posedge clk_i) disable iff (rst_i)
                (cur_i == CR_TEN && (nickel_i || dime_i)) |-> open_o); // R5
        end
    endgenerate

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
)(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                nickel_i,
    input  logic                dime_i,
    output logic                open_o,
    output logic [CREDIT_W-1:0] credit_o
);

    credit_e cur;
    credit_e nxt;
    logic    fire;

    vend_out #(.REG_OUT(REG_OUT)) u_out (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cur_i    (cur),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .fire_o   (fire),
        .open_o   (open_o)
    );

    vend_next u_next (
        .cur_i    (cur),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .fire_i   (fire),
        .nxt_o    (nxt)
    );

    vend_state_reg u_reg (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .nxt_i    (nxt),
        .cur_o    (cur)
    );

    assign credit_o = cur;

    AST_RETURN_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        fire |=> (credit_o == 2'b00)); // R7

    AST_DIME_NO_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (credit_o == 2'b01 && dime_i) |-> !fire); // R3

endmodule

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nick = 1'b0;
    logic       dime = 1'b0;
    logic       open0, open1;
    logic [1:0] cred0, cred1;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [1:0] m_st  = 2'b00;
    logic       m_reg = 1'b0;

    always #5 clk = ~clk;

    vend_ctrl #(.REG_OUT(1'b0)) u0 (
        .clk_i(clk), .rst_i(rst), .nickel_i(nick), .dime_i(dime),
        .open_o(open0), .credit_o(cred0)
    );

    vend_ctrl #(.REG_OUT(1'b1)) u1 (
        .clk_i(clk), .rst_i(rst), .nickel_i(nick), .dime_i(dime),
        .open_o(open1), .credit_o(cred1)
    );

    function automatic logic m_open(input logic [1:0] s, input logic n, input logic d);
        return s[1] & (s[0] | n | d);
    endfunction

    function automatic logic [1:0] m_next(input logic [1:0] s, input logic n, input logic d);
        logic [2:0] sum;
        if (m_open(s, n, d)) return 2'b00;
        sum = {1'b0, s} + (d ? 3'd2 : (n ? 3'd1 : 3'd0));
        return (sum > 3'd3) ? 2'b11 : sum[1:0];
    endfunction

    task automatic check(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic rs, input logic n, input logic d, input string tag);
        logic e_open;
        @(negedge clk);
        rst = rs; nick = n; dime = d;
        #1;
        e_open = rs ? 1'b0 : m_open(m_st, n, d);
        check(tag, "open direct", {1'b0, open0}, {1'b0, e_open});
        check(tag, "open registered", {1'b0, open1}, {1'b0, m_reg});
        check(tag, "credit direct", cred0, m_st);
        check(tag, "credit registered", cred1, m_st);
        @(posedge clk);
        m_reg = e_open;
        m_st  = rs ? 2'b00 : m_next(m_st, n, d);
    endtask

    task automatic t_reset;
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_nickels;
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_dimes;
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, "R7");
        step(1'b0, 1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, "R3");
        step(1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_idle;
        step(1'b0, 1'b0, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, "R10");
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b1, "R5");
        step(1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_reset_gate;
        step(1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b1, "R3");
        step(1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, 1'b0, "R9");
    endtask

    task automatic t_stream;
        for (int i = 0; i < 60; i++) begin
            logic n, d;
            n = ((i * 7) % 3) == 1;
            d = !n && ((i * 5) % 4) == 2;
            step(1'b0, n, d, "R8");
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        m_st = 2'b00; m_reg = 1'b0;
        t_reset();
        t_nickels();
        t_dimes();
        t_idle();
        t_reset_gate();
        t_stream();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule